// File: doc/BRIEF.md
# Two-Beam Gate Direction Detector

This block watches a single vehicle gate fitted with two light-beam sensors. One sits on the street side (outer) and one on the lot side (inner). Each sensor reads 1 while something interrupts its beam. From the order in which the beams are broken and cleared, the block decides whether a vehicle drove in or drove out. It then raises a one-cycle pulse on the matching output.

Both sensor lines first pass through a multi-flop synchronizer. A state machine then follows the sampled two-bit pattern. It advances only along the exact inward or outward order of four changes. A repeated sample leaves the machine where it is. Any other change parks it in a holding state, and it stays there until both beams are clear. A person crossing one beam, a vehicle that backs out, or a skipped step therefore never produces a pulse. Any sequence that does match a full vehicle pattern is treated as a vehicle, whatever caused it. A downstream occupancy counter would use the two pulses as its up and down commands.

Top module: `gate_dir_detect`

## Requirements
- R1: An asynchronous active-low reset forces both pulse outputs low at once and returns the detector to its idle state. A passage that was under way when reset arrived yields no pulse after reset is released.
- R2: With the sensor pair written {outer, inner}, the sample order 00, 10, 11, 01, 00 raises `enter_pulse`, and `exit_pulse` stays low.
- R3: The sample order 00, 01, 11, 10, 00 raises `exit_pulse`, and `enter_pulse` stays low.
- R4: Each pulse is high for exactly one clock cycle per passage. It goes high SYNC_STAGES+1 rising edges after the final 00 is applied at the inputs.
- R5: A pattern may be held for any number of cycles at any step without changing the outcome.
- R6: One beam broken and then cleared (10 then 00, or 01 then 00) produces no pulse.
- R7: A reversal (for example 10, 11, 10, 00) or a skipped step (for example 10, 01, 00 or 10, 11, 00) produces no pulse.
- R8: After an illegal change, no pulse follows until both beams have read 00. A valid passage that starts right after that 00 is then detected.
- R9: `enter_pulse` and `exit_pulse` are never high in the same cycle. Back-to-back passages separated by a single 00 sample each produce their own pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| outer_blk | input | 1 | Street-side beam, 1 while blocked |
| inner_blk | input | 1 | Lot-side beam, 1 while blocked |
| enter_pulse | output | 1 | One-cycle pulse per inward vehicle |
| exit_pulse | output | 1 | One-cycle pulse per outward vehicle |

## Verification
A pulse is due exactly SYNC_STAGES+1 rising edges after the final clear sample is driven. That is two synchronizer flops plus the registered output. Whenever the driver applies the closing 00 of a valid passage, it records the due cycle and the direction in a queue. The monitor compares both outputs at every falling edge. It expects a pulse only in the recorded cycle, and it expects both outputs low in every other cycle, including the cycle after a pulse. A pulse that comes early, comes late, lasts two cycles or is missing is therefore reported against the requirement being exercised.

// File: rtl/gate_dir_pkg.sv
package gate_dir_pkg;
  // Sensor pair encoding: bit 1 = outer beam, bit 0 = inner beam
  localparam logic [1:0] PAT_CLEAR = 2'b00;
  localparam logic [1:0] PAT_INNER = 2'b01;
  localparam logic [1:0] PAT_OUTER = 2'b10;
  localparam logic [1:0] PAT_BOTH  = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_IN1,    // outer only, heading in
    ST_IN2,    // both, heading in
    ST_IN3,    // inner only, heading in
    ST_OUT1,   // inner only, heading out
    ST_OUT2,   // both, heading out
    ST_OUT3,   // outer only, heading out
    ST_HOLD    // illegal step seen, wait for all clear
  } gate_state_e;
endpackage

// File: rtl/gate_sync.sv
module gate_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gate_seq_fsm.sv
module gate_seq_fsm
  import gate_dir_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] beams,
  output logic       enter_o,
  output logic       exit_o
);
  gate_state_e state_q, state_d;
  logic        enter_d, exit_d;

  // Advance one legal step, hold on a repeat, otherwise park in ST_HOLD
  function automatic gate_state_e step(input gate_state_e cur, input logic [1:0] here,
                                       input logic [1:0] nxt, input gate_state_e nxt_st,
                                       input logic [1:0] smp);
    if (smp == here)     return cur;
    else if (smp == nxt) return nxt_st;
    else                 return ST_HOLD;
  endfunction

  always_comb begin
    state_d = state_q;
    enter_d = 1'b0;
    exit_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        unique case (beams)
          PAT_CLEAR: state_d = ST_IDLE;
          PAT_OUTER: state_d = ST_IN1;
          PAT_INNER: state_d = ST_OUT1;
          default:   state_d = ST_HOLD;
        endcase
      end
      ST_IN1:  state_d = step(state_q, PAT_OUTER, PAT_BOTH,  ST_IN2,  beams);
      ST_IN2:  state_d = step(state_q, PAT_BOTH,  PAT_INNER, ST_IN3,  beams);
      ST_IN3: begin
        state_d = step(state_q, PAT_INNER, PAT_CLEAR, ST_IDLE, beams);
        enter_d = (beams == PAT_CLEAR);
      end
      ST_OUT1: state_d = step(state_q, PAT_INNER, PAT_BOTH,  ST_OUT2, beams);
      ST_OUT2: state_d = step(state_q, PAT_BOTH,  PAT_OUTER, ST_OUT3, beams);
      ST_OUT3: begin
        state_d = step(state_q, PAT_OUTER, PAT_CLEAR, ST_IDLE, beams);
        exit_d  = (beams == PAT_CLEAR);
      end
      ST_HOLD: state_d = (beams == PAT_CLEAR) ? ST_IDLE : ST_HOLD;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      enter_o <= 1'b0;
      exit_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      enter_o <= enter_d;
      exit_o  <= exit_d;
    end
  end

  // R9
  never_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(enter_o && exit_o));
  // R4
  enter_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_o |=> !enter_o);
  // R4
  exit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_o |=> !exit_o);
  // R8
  hold_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && beams != PAT_CLEAR) |=> (state_q == ST_HOLD && !enter_o && !exit_o));
  // R2
  enter_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_o |-> state_q == ST_IDLE);
  // R3
  exit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_o |-> state_q == ST_IDLE);
endmodule

// File: rtl/gate_dir_detect.sv
module gate_dir_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic outer_blk,
  input  logic inner_blk,
  output logic enter_pulse,
  output logic exit_pulse
);
  localparam int BEAM_W = 2;

  logic [BEAM_W-1:0] beams_sync;

  gate_sync #(.WIDTH(BEAM_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({outer_blk, inner_blk}),
    .q     (beams_sync)
  );

  gate_seq_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .beams   (beams_sync),
    .enter_o (enter_pulse),
    .exit_o  (exit_pulse)
  );
endmodule

// File: tb/tb_gate_dir_detect.sv
`timescale 1ns/1ps
module tb_gate_dir_detect;
  localparam int LAT = 3;  // two sync flops + registered output

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic outer_blk = 1'b0, inner_blk = 1'b0;
  logic enter_pulse, exit_pulse;

  gate_dir_detect dut (
    .clk(clk), .rst_n(rst_n), .outer_blk(outer_blk), .inner_blk(inner_blk),
    .enter_pulse(enter_pulse), .exit_pulse(exit_pulse)
  );

  always #2.5 clk = ~clk;  // 200 MHz

  typedef struct { int due; bit is_enter; string req; } exp_t;
  exp_t sb_q[$];

  int    cyc = 0;
  int    vectors = 0, miscompares = 0;
  bit    mon_on = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R1";
  int    pend = 0;  // 0 none, 1 enter, 2 exit
  string pend_req = "";

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare outputs against scoreboard every falling edge
  always @(negedge clk) begin
    if (mon_on) begin
      bit    ee, ex;
      string rq;
      ee = 1'b0; ex = 1'b0; rq = cur_req;
      while (sb_q.size() > 0 && sb_q[0].due < cyc) begin
        exp_t m;
        m = sb_q.pop_front();
        miscompares++;
        $display("FAIL %s: pulse due at cycle %0d never matched (actual none, expected %s)",
                 m.req, m.due, m.is_enter ? "enter" : "exit");
      end
      if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
        exp_t it;
        it = sb_q.pop_front();
        ee = it.is_enter; ex = !it.is_enter; rq = it.req;
      end
      vectors++;
      if (enter_pulse !== ee || exit_pulse !== ex) begin
        miscompares++;
        $display("FAIL %s: cycle %0d {enter,exit} actual %b%b expected %b%b",
                 rq, cyc, enter_pulse, exit_pulse, ee, ex);
      end
    end
  end

  task automatic put(input logic [1:0] p, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      {outer_blk, inner_blk} = p;
      if (i == 0 && pend != 0) begin
        exp_t it;
        it.due = cyc + LAT; it.is_enter = (pend == 1); it.req = pend_req;
        sb_q.push_back(it);
        pend = 0;
      end
    end
  endtask

  task automatic expect_next(input bit is_enter, input string rq);
    pend = is_enter ? 1 : 2;
    pend_req = rq;
  endtask

  task automatic settle();
    put(2'b00, 6);
  endtask

  initial begin
    // R1: outputs low while reset is held
    repeat (3) @(negedge clk);
    cur_req = "R1";
    mon_on = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R2 inward, one sample per step (R4 timing)
    cur_req = "R2";
    put(2'b10, 1); put(2'b11, 1); put(2'b01, 1);
    expect_next(1'b1, "R2"); put(2'b00, 1); settle();

    // R3 outward
    cur_req = "R3";
    put(2'b01, 2); put(2'b11, 2); put(2'b10, 2);
    expect_next(1'b0, "R3"); settle();

    // R5 long holds on every step
    cur_req = "R5";
    put(2'b10, 7); put(2'b11, 9); put(2'b01, 5);
    expect_next(1'b1, "R5"); settle();
    put(2'b01, 4); put(2'b11, 8); put(2'b10, 11);
    expect_next(1'b0, "R5"); settle();

    // R6 pedestrian on one beam
    cur_req = "R6";
    put(2'b10, 4); settle();
    put(2'b01, 4); settle();

    // R7 reversal and skipped steps
    cur_req = "R7";
    put(2'b10, 2); put(2'b11, 2); put(2'b10, 2); settle();
    put(2'b01, 2); put(2'b11, 2); put(2'b01, 2); settle();
    put(2'b10, 2); put(2'b01, 2); settle();
    put(2'b10, 2); put(2'b11, 2); settle();

    // R8 illegal step holds off detection until all clear
    cur_req = "R8";
    put(2'b11, 2); put(2'b01, 2); settle();
    put(2'b10, 2); put(2'b11, 2); put(2'b10, 2); put(2'b11, 2); put(2'b01, 2); settle();
    put(2'b11, 2); put(2'b00, 1);
    put(2'b01, 1); put(2'b11, 1); put(2'b10, 1);
    expect_next(1'b0, "R8"); settle();

    // R9 back-to-back passages with one clear sample between
    cur_req = "R9";
    put(2'b10, 1); put(2'b11, 1); put(2'b01, 1);
    expect_next(1'b1, "R9"); put(2'b00, 1);
    put(2'b10, 1); put(2'b11, 1); put(2'b01, 1);
    expect_next(1'b1, "R9"); put(2'b00, 1);
    put(2'b01, 1); put(2'b11, 1); put(2'b10, 1);
    expect_next(1'b0, "R9"); settle();

    // R1 reset in mid passage, then final clear gives no pulse
    cur_req = "R1";
    put(2'b10, 2); put(2'b11, 2); put(2'b01, 3);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    if (enter_pulse !== 1'b0 || exit_pulse !== 1'b0) begin
      miscompares++;
      $display("FAIL R1: in reset actual %b%b expected 00", enter_pulse, exit_pulse);
    end
    vectors++;
    @(negedge clk); rst_n = 1'b1;
    settle();

    vectors++;
    if (sb_q.size() != 0) begin
      miscompares++;
      $display("FAIL R4: %0d expected pulses outstanding (actual %0d, expected 0)",
               sb_q.size(), sb_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run hung (actual running, expected finished)");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule